// File: doc/BRIEF.md
# Flow-Through Burst SRAM with Dual Address Strobes

This block is a synchronous static memory with a flow-through read path and a two-bit burst address sequencer. Each word is 18 bits, split into two 9-bit byte lanes that can be written separately. The number of words is set by a parameter. A processor or a cache controller loads an address with one of two address strobes. After that, an advance input steps through a four-word group without a new address.

A strobe cycle captures the address and the three chip enables. The processor strobe takes priority and always starts a read. The controller strobe can write in the same cycle. In the cycles that follow, the advance input either steps the burst counter or holds it. A write in any of these cycles goes to the current burst address. A static order input selects linear order or exclusive-OR interleaved order. Read data is not registered, so the addressed word reaches the output in the same cycle as the edge that registered its address. The output-enable qualifier is combinational. It combines the asynchronous enable input with the internal read state.

Top module: `sync_burst_sram`

## Requirements
- R1: The address and the chip enables are captured only on an edge where a strobe is accepted. In other cycles a change on the chip enables or on the address has no effect on the burst or on the data output.
- R2: When both strobes are low, only the processor strobe acts. The processor strobe is ignored while `ce1_n` is high, and that cycle then behaves as if the processor strobe were high.
- R3: An access started by the processor strobe is a read. The write inputs have no effect in that cycle.
- R4: A controller-strobe cycle with `adsp_n` high, the device selected and a write requested writes `din` at the newly loaded address on that edge. Without a write request it starts a read.
- R5: In a cycle with no strobe, `adv_n` low steps the 2-bit burst counter and `adv_n` high holds it. After four steps the address is back at the start value.
- R6: With `mode` high, the low two address bits are the start value XOR the step count (start 2 gives 2,3,0,1). With `mode` low, they are the start value plus the step count, modulo 4. The upper address bits stay as loaded.
- R7: `gw_n` low writes both lanes. Otherwise `bwe_n` low writes each lane whose select is low: `bw_n[0]` selects bits 8:0 and `bw_n[1]` selects bits 17:9. `bwe_n` high with `gw_n` high is a read.
- R8: Reads are flow-through. After the edge that registers an address, `dout` shows the stored word at that address within the same cycle.
- R9: `dout_en` is high only when `oe_n` is low and a read is active. It follows `oe_n` without a clock. A write cycle turns it off, and it stays off in later cycles that are not strobes until a strobe starts a new read.
- R10: A strobe cycle with `ce2` low or `ce3_n` high deselects the device, as does a controller-strobe cycle with `ce1_n` high. While deselected, `dout_en` is low and cycles with no strobe neither write nor step the burst.
- R11: After synchronous reset the device is deselected and `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Word address, sampled on strobe cycles |
| ce1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Write of both lanes, active low |
| bwe_n | input | 1 | Lane write enable, active low |
| bw_n | input | 2 | Lane selects, active low; bit 0 selects bits 8:0, bit 1 selects bits 17:9 |
| mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | 18 | Write data |
| dout | output | 18 | Read data, flow-through |
| dout_en | output | 1 | Drive enable for the data pads |

## Verification
The bench writes every word and then reads it back as a four-beat burst from every start address in both orders. It therefore catches a counter that wraps at the wrong point or an order that ignores `mode`, because the wrong word then appears on `dout`. Three cases check the write inputs and the processor strobe: writes requested during a processor-strobe cycle, both strobes asserted together, and a processor strobe while `ce1_n` is high. A design that let writes through in the first case, or gave the controller strobe priority, would corrupt stored data, and the next read finds that. Lane writes with each select pattern would show up on the wrong half-word if the lanes were swapped. Chip enables are toggled in the middle of a burst, and writes are attempted while deselected, to catch enables that are sampled too often. The bench also checks that `dout_en` stays low after a write until a new read strobe, and that it follows `oe_n` between clock edges.

// File: rtl/sbs_pkg.sv
// Shared types and the burst-order function for the burst SRAM.
// Assumes a burst group of four words addressed by the two low bits.
package sbs_pkg;

    // Command from the strobe decoder to the burst sequencer.
    typedef enum logic [1:0] {
        SEQ_HOLD = 2'd0,
        SEQ_ADV  = 2'd1,
        SEQ_LOAD = 2'd2
    } seq_cmd_e;

    // Low address bits for a given start value and step count.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       interleave);
        logic [1:0] r;
        if (interleave) r = start ^ step;
        else            r = start + step;
        return r;
    endfunction

endpackage

// File: rtl/sbs_burst_seq.sv
// Burst address sequencer: keeps the loaded base address and a 2-bit step
// count, and gives both the current word address and the address the next
// edge will produce (used as the write address).
// Assumes AW >= 2 and that mode changes only while a new address is loaded.
module sbs_burst_seq
    import sbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_cmd_e      cmd,
    input  logic [AW-1:0] ld_addr,
    input  logic          mode,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] nxt_addr
);
    localparam int HI = AW - 1;

    logic [AW-1:0] base_q, base_d;
    logic [1:0]    step_q, step_d;

    // Next base and step from the command.
    always_comb begin
        base_d = base_q;
        step_d = step_q;
        case (cmd)
            SEQ_LOAD: begin
                base_d = ld_addr;
                step_d = 2'd0;
            end
            SEQ_ADV:  step_d = step_q + 2'd1;
            default:  ;
        endcase
    end

    // Register the burst state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            step_q <= 2'd0;
        end else begin
            base_q <= base_d;
            step_q <= step_d;
        end
    end

    // Form the current and next word addresses in the selected order.
    always_comb begin
        cur_addr = {base_q[HI:2], burst_low(base_q[1:0], step_q, mode)};
        nxt_addr = {base_d[HI:2], burst_low(base_d[1:0], step_d, mode)};
    end

    assert_load_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == SEQ_LOAD) |=> (cur_addr == $past(ld_addr)));

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == SEQ_HOLD) |=> ($stable(cur_addr) || !$stable(mode)));

    assert_wrap_four_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == SEQ_ADV && step_q == 2'd3) |=> (step_q == 2'd0));

    assert_upper_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == SEQ_ADV) |=> (cur_addr[HI:2] == $past(cur_addr[HI:2])));

endmodule

// File: rtl/sbs_ctrl.sv
// Strobe decoder and access state: picks the strobe that wins, decides
// select/deselect, lane write enables and the read-active state, and forms
// the data drive enable from the asynchronous output-enable input.
// Assumes chip enables matter only on strobe cycles.
module sbs_ctrl
    import sbs_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             oe_n,
    output seq_cmd_e         cmd,
    output logic [LANES-1:0] lane_we,
    output logic             dout_en
);
    logic             sel_q, rd_q;
    logic             proc_take, strobe, ce_ok;
    logic [LANES-1:0] req_lanes;

    // Strobe arbitration and chip-enable decode.
    always_comb begin
        proc_take = !adsp_n && !ce1_n;
        strobe    = proc_take || !adsc_n;
        ce_ok     = !ce1_n && ce2 && !ce3_n;
    end

    // Lanes requested by the write inputs.
    always_comb begin
        if (!gw_n)       req_lanes = {LANES{1'b1}};
        else if (!bwe_n) req_lanes = ~bw_n;
        else             req_lanes = '0;
    end

    // Sequencer command and lane write enables for this edge.
    always_comb begin
        cmd     = SEQ_HOLD;
        lane_we = '0;
        if (strobe) begin
            if (ce_ok) begin
                cmd = SEQ_LOAD;
                if (!proc_take) lane_we = req_lanes;
            end
        end else if (sel_q) begin
            cmd     = adv_n ? SEQ_HOLD : SEQ_ADV;
            lane_we = req_lanes;
        end
        if (!rst_n) lane_we = '0;
    end

    // Select and read-active state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            rd_q  <= 1'b0;
        end else if (strobe) begin
            sel_q <= ce_ok;
            rd_q  <= ce_ok && (lane_we == '0);
        end else if (sel_q && (lane_we != '0)) begin
            rd_q  <= 1'b0;
        end
    end

    // Drive enable: asynchronous output enable gated by read state.
    always_comb dout_en = !oe_n && rd_q && sel_q;

    assert_proc_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce1_n && ce2 && !ce3_n) |=> rd_q);

    assert_write_blanks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we != '0) |=> !dout_en);

    assert_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !ce_ok) |=> (!sel_q && !dout_en));

    assert_sel_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe) |=> $stable(sel_q));

    assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !oe_n);

endmodule

// File: rtl/sbs_array.sv
// Storage array: one word-addressed memory per byte lane, written on the
// rising edge when the lane enable is set, read combinationally.
// Assumes contents are undefined until written.
module sbs_array #(
    parameter int AW     = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we,
    input  logic [AW-1:0]           waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [AW-1:0]           raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        // Lane write on the clock edge.
        always_ff @(posedge clk) begin
            if (lane_we[g]) lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        // Flow-through lane read.
        assign rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/sync_burst_sram.sv
// Flow-through synchronous burst SRAM: strobe decoder, burst sequencer and
// lane-split storage. Writes go to the address the edge produces; reads show
// the registered address without a pipeline stage.
// Assumes mode is static while a burst is running.
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              mode,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);
    seq_cmd_e         cmd;
    logic [LANES-1:0] lane_we;
    logic [AW-1:0]    cur_addr, nxt_addr;

    sbs_ctrl #(.LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
        .cmd(cmd), .lane_we(lane_we), .dout_en(dout_en)
    );

    sbs_burst_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .ld_addr(addr), .mode(mode),
        .cur_addr(cur_addr), .nxt_addr(nxt_addr)
    );

    sbs_array #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
        .clk(clk), .lane_we(lane_we), .waddr(nxt_addr), .wdata(din),
        .raddr(cur_addr), .rdata(dout)
    );

    assert_no_en_in_reset_R11: assert property (@(posedge clk)
        !rst_n |=> !dout_en);

endmodule

// File: tb/sync_burst_sram_test.sv
`timescale 1ns/1ps
module sync_burst_sram_test;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] addr = '0;
    logic ce1_n = 0, ce2 = 1, ce3_n = 0;
    logic adsp_n = 1, adsc_n = 1, adv_n = 1;
    logic gw_n = 1, bwe_n = 1, mode = 0, oe_n = 0;
    logic [1:0] bw_n = 2'b11;
    logic [17:0] din = '0;
    logic [17:0] dout;
    logic dout_en;

    int checks = 0, errors = 0;
    logic [17:0] ref_mem [DEPTH];
    logic [AW-1:0] m_base = '0;
    logic [1:0] m_cnt = 0;
    logic m_sel = 0, m_rd = 0;

    sync_burst_sram #(.AW(AW)) uut (.*);

    always #2 clk = ~clk;

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] lo;
        lo = mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    function automatic logic [17:0] pat(input int a, input int k);
        return 18'((a * 1031 + k * 4099) ^ 18'h2A5A5);
    endfunction

    task automatic fail(input string tag, input logic [17:0] act, input logic [17:0] exp);
        errors++;
        $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    endtask

    task automatic ref_write(input logic [1:0] wl);
        logic [AW-1:0] a;
        a = m_addr();
        if (wl[0]) ref_mem[a][8:0]  = din[8:0];
        if (wl[1]) ref_mem[a][17:9] = din[17:9];
    endtask

    // One clock cycle: update the reference from the requirements, clock, then compare.
    task automatic tick(input string tag);
        logic p, strobe, ok, expen;
        logic [1:0] wl;
        p = !adsp_n && !ce1_n;
        strobe = p || !adsc_n;
        wl = !gw_n ? 2'b11 : (!bwe_n ? ~bw_n : 2'b00);
        if (strobe) begin
            ok = !ce1_n && ce2 && !ce3_n;
            if (ok) begin
                m_base = addr; m_cnt = 0; m_sel = 1;
                if (p) wl = 2'b00;
                if (wl != 0) ref_write(wl);
                m_rd = (wl == 0);
            end else begin
                m_sel = 0; m_rd = 0;
            end
        end else if (m_sel) begin
            if (!adv_n) m_cnt = m_cnt + 1;
            if (wl != 0) begin ref_write(wl); m_rd = 0; end
        end
        @(posedge clk); #1;
        expen = m_sel && m_rd && !oe_n;
        checks++;
        if (dout_en !== expen) fail({tag, " dout_en"}, 18'(dout_en), 18'(expen));
        else if (expen) begin
            checks++;
            if (dout !== ref_mem[m_addr()]) fail({tag, " dout"}, dout, ref_mem[m_addr()]);
        end
    endtask

    task automatic idle();
        adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 2'b11;
        ce1_n = 0; ce2 = 1; ce3_n = 0; oe_n = 0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (dout_en !== 1'b0) fail("R11 reset", 18'(dout_en), 18'h0); // R11
        rst_n = 1;

        // R4 R7: controller-strobe full writes fill the whole array.
        for (int a = 0; a < DEPTH; a++) begin
            idle(); adsc_n = 0; gw_n = 0; addr = AW'(a); din = pat(a, 0);
            tick("R4 fill");
        end

        // R3 R5 R6 R8 R1: processor-strobe bursts from every start in both orders.
        for (int md = 0; md < 2; md++) begin
            for (int a = 0; a < DEPTH; a++) begin
                idle(); mode = md[0]; adsp_n = 0; addr = AW'(a);
                gw_n = 0; din = ~pat(a, 9);               // R3: must not write
                tick("R3 R8 start");
                for (int s = 0; s < 4; s++) begin
                    idle(); adv_n = 0;
                    ce2 = s[0]; ce3_n = s[1]; addr = ~AW'(a);  // R1: not sampled
                    tick(md ? "R6 R1 interleaved step" : "R6 R1 linear step");
                end
                idle(); tick("R5 hold after wrap");
            end
        end

        // R7: lane writes inside a burst, each select pattern, then read back.
        for (int pass = 0; pass < 4; pass++) begin
            idle(); mode = pass[0]; adsc_n = 0; addr = AW'(8 + pass * 4);
            tick("R4 controller read start");
            for (int s = 0; s < 3; s++) begin
                idle(); adv_n = 0; din = pat(s, pass + 3);
                if (pass == 3) gw_n = 0;
                else begin bwe_n = 0; bw_n = 2'(pass + s); end
                tick("R7 lane write");
            end
            idle(); tick("R9 stays off after write");
            idle(); adsp_n = 0; addr = AW'(8 + pass * 4); tick("R7 readback start");
            for (int s = 0; s < 3; s++) begin
                idle(); adv_n = 0; tick("R7 readback");
            end
        end

        // R2: both strobes with write request -> read; processor strobe with ce1_n high ignored.
        idle(); adsp_n = 0; adsc_n = 0; gw_n = 0; addr = 6'd20; din = 18'h3FFFF;
        tick("R2 priority");
        idle(); adsp_n = 0; ce1_n = 1; adv_n = 0; addr = 6'd40;
        tick("R2 ignored strobe advances");
        idle(); adsp_n = 0; addr = 6'd20; tick("R2 check unchanged");

        // R10: deselects and ignored writes.
        idle(); adsp_n = 0; ce2 = 0; addr = 6'd30; tick("R10 ce2 deselect");
        idle(); gw_n = 0; adv_n = 0; din = 18'h12345; tick("R10 write ignored");
        idle(); adsp_n = 0; addr = 6'd30; tick("R10 readback");
        idle(); adsc_n = 0; ce1_n = 1; tick("R10 ce1 controller deselect");
        idle(); adsp_n = 0; ce3_n = 1; addr = 6'd31; tick("R10 ce3 deselect");
        idle(); adsc_n = 0; addr = 6'd31; tick("R10 reselect read");

        // R9: asynchronous output enable.
        oe_n = 1; #1;
        checks++;
        if (dout_en !== 1'b0) fail("R9 oe high", 18'(dout_en), 18'h0);
        oe_n = 0; #1;
        checks++;
        if (dout_en !== 1'b1) fail("R9 oe low", 18'(dout_en), 18'h1);
        idle(); oe_n = 1; tick("R9 oe high read");
        idle(); adsc_n = 0; gw_n = 0; addr = 6'd31; din = 18'h0F0F0; tick("R9 R4 write blanks");
        idle(); tick("R9 off until strobe");
        idle(); adsc_n = 0; addr = 6'd31; tick("R4 read back write");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule